// File: doc/BRIEF.md
# Interrupt line pending and enable state

This block keeps the per-line state of a small vectored interrupt controller. Every external request line owns three bits: enable, pending and active. A rising edge on a request input makes the line pending. A processor core takes the lowest-numbered line that is both pending and enabled through an acknowledge strobe, and it reports the end of the handler through a return strobe. The line count is a parameter of up to 32.

Software reaches the state through a small word-wide write/read port with four word selects. Two words set and clear enables, and two words set and clear pending. Only bit positions written as 1 take effect. Writes carry a security attribute, and a non-secure write only touches lines that a parameter marks as non-secure targeted. The pending logic treats requests as level sensitive. A clear-pending write has no effect while the line's input is still high. When the handler returns and the input is still high, pending is set again, so a held request keeps rerunning its handler and is never dropped.

Top module: `irq_state_ctrl`

## Requirements
- R1: A 0-to-1 transition on `irq_in[i]`, as seen between two consecutive clock edges, makes line i pending at the next clock edge, whether or not the line is enabled. After reset the previous level of every input is taken as 0.
- R2: A write with `bus_addr`=0 sets enable for each line whose `bus_wdata` bit is 1, and a write with `bus_addr`=1 clears enable for each such line. Bits written as 0 in any of the four words leave the line unchanged.
- R3: A write with `bus_addr`=2 makes each line whose `bus_wdata` bit is 1 pending. Data bits at positions at or above NUM_LINES are ignored.
- R4: A write with `bus_addr`=3 clears pending for each line whose `bus_wdata` bit is 1, but only if that line's `irq_in` is 0 in the same cycle. If the input is 1, the pending bit stays as it was. Any set source (edge, set-pending write or return re-latch) beats a clear in the same cycle.
- R5: Reads are combinational. `bus_addr`=0 or 1 returns the enable vector, and `bus_addr`=2 or 3 returns the pending vector. Line i is on bit i, and bits at or above NUM_LINES read 0.
- R6: `irq_req` is 1 exactly when at least one line is both pending and enabled. A disabled line still becomes pending but does not raise `irq_req`.
- R7: A `core_ack` pulse with no active line and `irq_req`=1 makes the lowest-numbered pending and enabled line active at the next edge. `act_valid` becomes 1, `act_id` shows its number, and its pending bit clears, unless a set source hits that line in the same cycle. An acknowledge while a line is active, or with nothing eligible, changes nothing.
- R8: A `core_ret` pulse while `act_valid`=1 clears `act_valid` at the next edge. If the active line's `irq_in` is 1 in that cycle, that line becomes pending again.
- R9: A request pulse that goes low before the handler returns produces exactly one activation.
- R10: When `bus_nonsec`=1, a write affects only lines whose bit in NS_MASK is 1. When `bus_nonsec`=0, a write may affect every line.
- R11: After reset every enable, pending and active bit is 0, and `irq_req`, `act_valid` and `act_id` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | NUM_LINES | Request inputs, synchronous to clk |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 2 | Word select: 0 set-enable, 1 clear-enable, 2 set-pending, 3 clear-pending |
| bus_nonsec | input | 1 | Write is non-secure |
| bus_wdata | input | DATA_W | Write data, one bit per line |
| bus_rdata | output | DATA_W | Enable or pending vector for the selected word |
| core_ack | input | 1 | Core takes the highest-ranked request |
| core_ret | input | 1 | Handler of the active line has returned |
| irq_req | output | 1 | Some line is pending and enabled |
| act_valid | output | 1 | A line is active |
| act_id | output | ID_W | Number of the active line |

## Verification
The bench goes after the clear-pending write that arrives while the input is still high. A design that clears unconditionally would lose a held request and leave the pending read at 0. It also drives return with the input still high and checks that pending comes back. A design that only latches on edges would show no pending after the return and never rerun the handler. Other checks cover an acknowledge that meets a fresh edge in the same cycle, where a wrong priority would drop the new event. They also cover non-secure writes to secure lines, which a design that ignores the attribute would let through, and a second acknowledge during a handler, which must not move the active number.

// File: rtl/irq_pkg.sv
package irq_pkg;

   typedef enum logic [1:0] {
      W_EN_SET   = 2'd0,
      W_EN_CLR   = 2'd1,
      W_PEND_SET = 2'd2,
      W_PEND_CLR = 2'd3
   } word_e;

   localparam int unsigned MAX_LINES = 32;

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
   parameter int unsigned N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   output logic [N-1:0] rise
);

   for (genvar i = 0; i < N; i++) begin : g_line
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= lvl[i];
      end
      assign rise[i] = lvl[i] & ~prev_q;
   end

endmodule

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
   import irq_pkg::*;
#(
   parameter int unsigned N       = 8,
   parameter int unsigned DW      = 32,
   parameter logic [31:0] NS_MASK = 32'h0
) (
   input  logic          wr,
   input  logic [1:0]    addr,
   input  logic          nonsec,
   input  logic [DW-1:0] wdata,
   output logic [N-1:0]  en_set,
   output logic [N-1:0]  en_clr,
   output logic [N-1:0]  pd_set,
   output logic [N-1:0]  pd_clr
);

   localparam logic [N-1:0] NS_LINES = NS_MASK[N-1:0];

   logic [N-1:0] gate;
   logic [N-1:0] bits;

   assign gate = nonsec ? NS_LINES : {N{1'b1}};
   assign bits = wdata[N-1:0] & gate;

   if (DW > N) begin : g_spare
      logic unused_hi;
      assign unused_hi = ^wdata[DW-1:N];
   end

   always_comb begin
      en_set = '0;
      en_clr = '0;
      pd_set = '0;
      pd_clr = '0;
      if (wr) begin
         case (word_e'(addr))
            W_EN_SET:   en_set = bits;
            W_EN_CLR:   en_clr = bits;
            W_PEND_SET: pd_set = bits;
            W_PEND_CLR: pd_clr = bits;
            default:    ;
         endcase
      end
   end

endmodule

// File: rtl/irq_line_bank.sv
module irq_line_bank #(
   parameter int unsigned N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   input  logic [N-1:0] rise,
   input  logic [N-1:0] en_set,
   input  logic [N-1:0] en_clr,
   input  logic [N-1:0] pd_set,
   input  logic [N-1:0] pd_clr,
   input  logic [N-1:0] ack_hit,
   input  logic [N-1:0] ret_hit,
   output logic [N-1:0] en_q,
   output logic [N-1:0] pend_q
);

   for (genvar i = 0; i < N; i++) begin : g_line
      logic set_src;
      logic clr_src;

      assign set_src = rise[i] | pd_set[i] | (ret_hit[i] & lvl[i]);
      assign clr_src = ack_hit[i] | (pd_clr[i] & ~lvl[i]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_q[i]   <= 1'b0;
            pend_q[i] <= 1'b0;
         end else begin
            if (en_set[i])      en_q[i] <= 1'b1;
            else if (en_clr[i]) en_q[i] <= 1'b0;

            if (set_src)        pend_q[i] <= 1'b1;
            else if (clr_src)   pend_q[i] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/irq_rank.sv
module irq_rank #(
   parameter int unsigned N   = 8,
   parameter int unsigned IDW = 3
) (
   input  logic [N-1:0]   elig,
   output logic           found,
   output logic [IDW-1:0] id,
   output logic [N-1:0]   onehot
);

   assign found = |elig;

   if (N == 1) begin : g_single
      assign id     = '0;
      assign onehot = elig;
   end else begin : g_multi
      assign onehot = elig & (~elig + N'(1));
      always_comb begin
         id = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) id = IDW'(i);
         end
      end
   end

endmodule

// File: rtl/irq_state_ctrl.sv
module irq_state_ctrl
   import irq_pkg::*;
#(
   parameter int unsigned NUM_LINES = 8,
   parameter int unsigned DATA_W    = 32,
   parameter logic [31:0] NS_MASK   = 32'h0000_00F0,
   localparam int unsigned ID_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_in,
   input  logic                 bus_wr,
   input  logic [1:0]           bus_addr,
   input  logic                 bus_nonsec,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic                 core_ack,
   input  logic                 core_ret,
   output logic                 irq_req,
   output logic                 act_valid,
   output logic [ID_W-1:0]      act_id
);

   if (NUM_LINES < 1 || NUM_LINES > MAX_LINES) begin : g_bad_lines
      $error("NUM_LINES must lie between 1 and 32");
   end
   if (DATA_W < NUM_LINES) begin : g_bad_width
      $error("DATA_W must hold one bit per line");
   end

   logic [NUM_LINES-1:0] rise;
   logic [NUM_LINES-1:0] en_set, en_clr, pd_set, pd_clr;
   logic [NUM_LINES-1:0] en_vec, pend_vec;
   logic [NUM_LINES-1:0] elig, pick_oh;
   logic [NUM_LINES-1:0] ack_hit, ret_hit;
   logic                 pick_found;
   logic [ID_W-1:0]      pick_id;
   logic                 ack_take, ret_take;
   logic [NUM_LINES-1:0] rd_sel;

   irq_edge_detect #(.N(NUM_LINES)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (irq_in),
      .rise (rise)
   );

   irq_bus_decode #(.N(NUM_LINES), .DW(DATA_W), .NS_MASK(NS_MASK)) u_dec (
      .wr    (bus_wr),
      .addr  (bus_addr),
      .nonsec(bus_nonsec),
      .wdata (bus_wdata),
      .en_set(en_set),
      .en_clr(en_clr),
      .pd_set(pd_set),
      .pd_clr(pd_clr)
   );

   assign elig = pend_vec & en_vec;

   irq_rank #(.N(NUM_LINES), .IDW(ID_W)) u_rank (
      .elig  (elig),
      .found (pick_found),
      .id    (pick_id),
      .onehot(pick_oh)
   );

   assign ack_take = core_ack & ~act_valid & pick_found;
   assign ret_take = core_ret & act_valid;
   assign ack_hit  = ack_take ? pick_oh : '0;
   assign ret_hit  = ret_take ? (NUM_LINES'(1) << act_id) : '0;

   irq_line_bank #(.N(NUM_LINES)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl    (irq_in),
      .rise   (rise),
      .en_set (en_set),
      .en_clr (en_clr),
      .pd_set (pd_set),
      .pd_clr (pd_clr),
      .ack_hit(ack_hit),
      .ret_hit(ret_hit),
      .en_q   (en_vec),
      .pend_q (pend_vec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_valid <= 1'b0;
         act_id    <= '0;
      end else if (ack_take) begin
         act_valid <= 1'b1;
         act_id    <= pick_id;
      end else if (ret_take) begin
         act_valid <= 1'b0;
      end
   end

   assign irq_req   = pick_found;
   assign rd_sel    = bus_addr[1] ? pend_vec : en_vec;
   assign bus_rdata = DATA_W'(rd_sel);

endmodule

// File: rtl/irq_state_ctrl_chk.sv
module irq_state_ctrl_chk #(
   parameter int unsigned N       = 8,
   parameter int unsigned ID_W    = 3,
   parameter logic [31:0] NS_MASK = 32'h0
) (
   input logic            clk,
   input logic            rst_n,
   input logic [N-1:0]    irq_in,
   input logic            bus_wr,
   input logic [1:0]      bus_addr,
   input logic            bus_nonsec,
   input logic            core_ack,
   input logic            core_ret,
   input logic            irq_req,
   input logic            act_valid,
   input logic [ID_W-1:0] act_id,
   input logic [N-1:0]    pend_vec,
   input logic [N-1:0]    en_vec
);

   localparam logic [N-1:0] NS_LINES = NS_MASK[N-1:0];

   logic [N-1:0] seen_q;
   logic [N-1:0] up_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= '0;
      else        seen_q <= irq_in;
   end
   assign up_now = irq_in & ~seen_q;

   // R1: every fresh edge leaves its line pending
   p_edge_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_vec & $past(up_now)) == $past(up_now)));

   // R4: a clear-pending write cannot drop a line whose input is high
   p_clr_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd3 && !core_ack)
      |=> ((pend_vec & $past(pend_vec & irq_in)) == $past(pend_vec & irq_in)));

   // R7: activation needs a request and an acknowledge
   p_ack_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act_valid) |-> $past(irq_req && core_ack));

   // R7: the active line holds until return
   p_one_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (act_valid && !core_ret) |=> (act_valid && $stable(act_id)));

   // R8: return ends the activation
   p_ret_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (act_valid && core_ret) |=> !act_valid);

   // R8: a held input is pending again after return
   p_ret_relatch_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (act_valid && core_ret && irq_in[act_id]) |=> pend_vec[$past(act_id)]);

   // R10: non-secure writes never change enables of secure lines
   p_ns_guard_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_nonsec) |=> (((en_vec ^ $past(en_vec)) & ~NS_LINES) == '0));

endmodule

bind irq_state_ctrl irq_state_ctrl_chk #(
   .N(NUM_LINES), .ID_W(ID_W), .NS_MASK(NS_MASK)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_in    (irq_in),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_nonsec(bus_nonsec),
   .core_ack  (core_ack),
   .core_ret  (core_ret),
   .irq_req   (irq_req),
   .act_valid (act_valid),
   .act_id    (act_id),
   .pend_vec  (pend_vec),
   .en_vec    (en_vec)
);

// File: tb/irq_state_ctrl_tb.sv
`timescale 1ns/100ps
module irq_state_ctrl_tb;

   localparam int unsigned NL = 8;
   localparam int unsigned DW = 32;
   localparam int unsigned IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NL-1:0] irq_in = '0;
   logic          bus_wr = 1'b0;
   logic [1:0]    bus_addr = 2'd0;
   logic          bus_nonsec = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          core_ack = 1'b0;
   logic          core_ret = 1'b0;
   logic          irq_req;
   logic          act_valid;
   logic [IW-1:0] act_id;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   irq_state_ctrl #(.NUM_LINES(NL), .DATA_W(DW), .NS_MASK(32'h0000_00F0)) u_dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_nonsec(bus_nonsec),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .core_ack(core_ack), .core_ret(core_ret),
      .irq_req(irq_req), .act_valid(act_valid), .act_id(act_id)
   );

   typedef struct packed {
      logic [7:0]  lvl;
      logic        wr;
      logic [1:0]  adr;
      logic        ns;
      logic [31:0] wd;
      logic [7:0]  en;
      logic [7:0]  pd;
      logic        rq;
   } vec_t;

   localparam vec_t TBL [15] = '{
      '{8'h00, 1'b1, 2'd0, 1'b0, 32'h0000_000F, 8'h0F, 8'h00, 1'b0},
      '{8'h00, 1'b1, 2'd0, 1'b1, 32'h0000_00FF, 8'hFF, 8'h00, 1'b0},
      '{8'h00, 1'b1, 2'd1, 1'b1, 32'h0000_0003, 8'hFF, 8'h00, 1'b0},
      '{8'h00, 1'b1, 2'd1, 1'b0, 32'h0000_0003, 8'hFC, 8'h00, 1'b0},
      '{8'h00, 1'b1, 2'd2, 1'b0, 32'hFFFF_FF01, 8'hFC, 8'h01, 1'b0},
      '{8'h02, 1'b0, 2'd0, 1'b0, 32'h0000_0000, 8'hFC, 8'h03, 1'b0},
      '{8'h02, 1'b1, 2'd3, 1'b0, 32'h0000_0003, 8'hFC, 8'h02, 1'b0},
      '{8'h00, 1'b1, 2'd3, 1'b0, 32'h0000_0002, 8'hFC, 8'h00, 1'b0},
      '{8'h10, 1'b0, 2'd0, 1'b0, 32'h0000_0000, 8'hFC, 8'h10, 1'b1},
      '{8'h10, 1'b1, 2'd3, 1'b1, 32'h0000_0010, 8'hFC, 8'h10, 1'b1},
      '{8'h00, 1'b1, 2'd3, 1'b1, 32'h0000_0010, 8'hFC, 8'h00, 1'b0},
      '{8'h00, 1'b1, 2'd2, 1'b1, 32'h0000_0003, 8'hFC, 8'h00, 1'b0},
      '{8'h00, 1'b1, 2'd2, 1'b1, 32'h0000_0020, 8'hFC, 8'h20, 1'b1},
      '{8'h00, 1'b1, 2'd2, 1'b0, 32'h0000_0000, 8'hFC, 8'h20, 1'b1},
      '{8'h00, 1'b1, 2'd3, 1'b0, 32'h0000_0020, 8'hFC, 8'h00, 1'b0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      bus_addr = a;
      #0.2;
      d = bus_rdata;
   endtask

   // drive at a falling edge, let one rising edge pass, return to idle
   task automatic step(input logic [7:0] l, input logic w, input logic [1:0] a,
                       input logic ns, input logic [31:0] d,
                       input logic ak, input logic rt);
      irq_in = l; bus_wr = w; bus_addr = a; bus_nonsec = ns; bus_wdata = d;
      core_ack = ak; core_ret = rt;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0; core_ack = 1'b0; core_ret = 1'b0; bus_wdata = '0;
   endtask

   task automatic chk_pend(input string tag, input logic [7:0] exp);
      logic [31:0] d;
      rd(2'd2, d);
      chk(tag, d, {24'h0, exp});
   endtask

   task automatic chk_act(input string tag, input logic v, input logic [IW-1:0] id);
      chk({tag, " act_valid"}, {31'h0, act_valid}, {31'h0, v});
      if (v) chk({tag, " act_id"}, {29'h0, act_id}, {29'h0, id});
   endtask

   initial begin
      repeat (300000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11: state after reset
      chk("R11 irq_req", {31'h0, irq_req}, 32'h0);
      chk("R11 act_valid", {31'h0, act_valid}, 32'h0);
      chk("R11 act_id", {29'h0, act_id}, 32'h0);
      rd(2'd0, d); chk("R11 enable", d, 32'h0);
      rd(2'd2, d); chk("R11 pending", d, 32'h0);

      // register-port table: R1 R2 R3 R4 R5 R6 R10
      for (int k = 0; k < 15; k++) begin
         step(TBL[k].lvl, TBL[k].wr, TBL[k].adr, TBL[k].ns, TBL[k].wd, 1'b0, 1'b0);
         rd(2'd0, d); chk($sformatf("R2 R10 row%0d enable word0", k), d, {24'h0, TBL[k].en});
         rd(2'd1, d); chk($sformatf("R5 row%0d enable word1", k), d, {24'h0, TBL[k].en});
         rd(2'd2, d); chk($sformatf("R1 R3 R4 row%0d pending word2", k), d, {24'h0, TBL[k].pd});
         rd(2'd3, d); chk($sformatf("R5 row%0d pending word3", k), d, {24'h0, TBL[k].pd});
         chk($sformatf("R6 row%0d irq_req", k), {31'h0, irq_req}, {31'h0, TBL[k].rq});
      end

      // R7: acknowledge with nothing eligible
      step(8'h00, 1'b0, 2'd0, 1'b0, 32'h0, 1'b1, 1'b0);
      chk_act("R7 idle ack", 1'b0, 3'd0);

      // R7: ranking by lowest number, second ack ignored
      step(8'h00, 1'b1, 2'd2, 1'b0, 32'h24, 1'b0, 1'b0);
      chk("R6 req two pending", {31'h0, irq_req}, 32'h1);
      step(8'h00, 1'b0, 2'd0, 1'b0, 32'h0, 1'b1, 1'b0);
      chk_act("R7 first ack", 1'b1, 3'd2);
      chk_pend("R7 first ack pending", 8'h20);
      step(8'h00, 1'b0, 2'd0, 1'b0, 32'h0, 1'b1, 1'b0);
      chk_act("R7 ack while active", 1'b1, 3'd2);
      chk_pend("R7 ack while active pending", 8'h20);
      step(8'h00, 1'b0, 2'd0, 1'b0, 32'h0, 1'b0, 1'b1);
      chk_act("R8 return", 1'b0, 3'd0);
      chk_pend("R8 return low input", 8'h20);
      step(8'h00, 1'b0, 2'd0, 1'b0, 32'h0, 1'b1, 1'b0);
      chk_act("R7 next ack", 1'b1, 3'd5);
      step(8'h00, 1'b0, 2'd0, 1'b0, 32'h0, 1'b0, 1'b1);
      chk_pend("R8 drained", 8'h00);

      // R8: held input reruns the handler
      step(8'h08, 1'b0, 2'd0, 1'b0, 32'h0, 1'b0, 1'b0);
      step(8'h08, 1'b0, 2'd0, 1'b0, 32'h0, 1'b1, 1'b0);
      chk_act("R8 held ack", 1'b1, 3'd3);
      chk_pend("R8 held ack pending", 8'h00);
      step(8'h08, 1'b0, 2'd0, 1'b0, 32'h0, 1'b0, 1'b1);
      chk_act("R8 held return", 1'b0, 3'd0);
      chk_pend("R8 relatch", 8'h08);
      step(8'h08, 1'b0, 2'd0, 1'b0, 32'h0, 1'b1, 1'b0);
      chk_act("R8 rerun", 1'b1, 3'd3);
      step(8'h00, 1'b0, 2'd0, 1'b0, 32'h0, 1'b0, 1'b0);
      step(8'h00, 1'b0, 2'd0, 1'b0, 32'h0, 1'b0, 1'b1);
      chk_pend("R8 low at return", 8'h00);
      chk("R8 req after low return", {31'h0, irq_req}, 32'h0);

      // R9: one-cycle pulse, one activation
      step(8'h40, 1'b0, 2'd0, 1'b0, 32'h0, 1'b0, 1'b0);
      step(8'h00, 1'b0, 2'd0, 1'b0, 32'h0, 1'b0, 1'b0);
      step(8'h00, 1'b0, 2'd0, 1'b0, 32'h0, 1'b1, 1'b0);
      chk_act("R9 pulse ack", 1'b1, 3'd6);
      step(8'h00, 1'b0, 2'd0, 1'b0, 32'h0, 1'b0, 1'b1);
      step(8'h00, 1'b0, 2'd0, 1'b0, 32'h0, 1'b1, 1'b0);
      chk_act("R9 no second activation", 1'b0, 3'd0);
      chk_pend("R9 pending after pulse", 8'h00);

      // R6 R8: disabled line still re-latches at return
      step(8'h08, 1'b0, 2'd0, 1'b0, 32'h0, 1'b0, 1'b0);
      step(8'h08, 1'b0, 2'd0, 1'b0, 32'h0, 1'b1, 1'b0);
      chk_act("R6 ack line3", 1'b1, 3'd3);
      step(8'h08, 1'b1, 2'd1, 1'b0, 32'h08, 1'b0, 1'b0);
      step(8'h08, 1'b0, 2'd0, 1'b0, 32'h0, 1'b0, 1'b1);
      chk_pend("R6 disabled relatch", 8'h08);
      chk("R6 disabled no req", {31'h0, irq_req}, 32'h0);
      step(8'h00, 1'b1, 2'd3, 1'b0, 32'h08, 1'b0, 1'b0);
      step(8'h00, 1'b1, 2'd0, 1'b0, 32'h08, 1'b0, 1'b0);
      chk_pend("R4 cleared after low", 8'h00);

      // R7 R4: fresh edge in the acknowledge cycle keeps pending
      step(8'h80, 1'b0, 2'd0, 1'b0, 32'h0, 1'b0, 1'b0);
      step(8'h00, 1'b0, 2'd0, 1'b0, 32'h0, 1'b0, 1'b0);
      step(8'h80, 1'b0, 2'd0, 1'b0, 32'h0, 1'b1, 1'b0);
      chk_act("R7 ack with edge", 1'b1, 3'd7);
      chk_pend("R7 edge beats ack clear", 8'h80);
      step(8'h80, 1'b0, 2'd0, 1'b0, 32'h0, 1'b0, 1'b1);
      chk_pend("R8 held line7 return", 8'h80);
      step(8'h00, 1'b1, 2'd3, 1'b0, 32'h80, 1'b0, 1'b0);
      chk_pend("R4 final clear", 8'h00);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule